// File: doc/BRIEF.md
# Memory Device Test Access Port

This block is the boundary-scan test port of a synchronous memory device. A tester drives a test clock, a mode-select line and serial data. A 16-state controller sequences capture, shift and update phases. A held instruction chooses which register sits between the serial input and the serial output.

Four scan registers are provided. The instruction register is 3 bits, the bypass register 1 bit, the identification register 32 bits and the boundary register 54 bits. The boundary register takes a parallel snapshot of the device pins from an input vector. Two of the instructions drive an output-disable line, which the pad ring uses to tri-state every device output. The instruction set departs from full 1149.1 compliance in two ways. The external-test code tri-states the outputs and has no drive-from-register stage. The sample code captures only and has no preload update.

Top module: `mem_tap`

## Requirements
- R1: Holding rst_ni low, or five consecutive rising edges of tck_i with tms_i high, puts the controller in Test-Logic-Reset. There the active instruction becomes IDCODE (001), out_disable_o is low and tdo_en_o is low.
- R2: The controller follows the standard 16-state sequence on tms_i at the rising edge of tck_i. Moving Shift-DR to Exit1 to Pause to Exit2 and back to Shift-DR preserves the register contents. Shifting resumes where it stopped.
- R3: Capture-IR loads 001 into the instruction shift stage. Shift-IR moves it out LSB first, while tdi_i enters at the MSB.
- R4: A shifted instruction takes effect only on leaving Update-IR. While a new code is being shifted, out_disable_o keeps the value set by the previous instruction.
- R5: out_disable_o is high while the active instruction is 000 (external test) or 010 (sample with tri-state). It is low for every other code.
- R6: Under 000, 010 and 100 (sample), Capture-DR copies bsr_capture_i into the 54-bit boundary register. Shift-DR moves it out bit 0 first.
- R7: Under 001, Capture-DR loads the identification word. Bit 0 is 1, bits 11:1 are 00011100100, bits 17:12 are the reserved parameter (default 0), bits 22:18 are 00011, bits 27:23 are 00111 and bits 31:28 are the revision parameter (default 0). It shifts out bit 0 first, and tdi_i reappears after 32 shifts.
- R8: Under 111 and the reserved codes 011, 101 and 110, the 1-bit bypass register is selected. It captures 0, so the first bit out is 0 and tdi_i reappears one shift later.
- R9: tdo_o changes only on the falling edge of tck_i. tdo_en_o is high exactly in the half-cycles that follow a falling edge in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in, sampled on rising edge |
| bsr_capture_i | input | 54 | Parallel pin snapshot for the boundary register |
| tdo_o | output | 1 | Serial data out, launched on falling edge |
| tdo_en_o | output | 1 | Serial output enable |
| out_disable_o | output | 1 | Forces device outputs to high impedance |

## Verification
out_disable_o is due on the rising edge that leaves Update-IR or Test-Logic-Reset. Each scan bit is due on the falling edge after the rising edge that captured or shifted it, so the first bit appears one half-cycle after Shift-DR or Shift-IR is entered. Inputs change 5 ns after a rising edge. All outputs are compared 5 ns after the falling edge, against a queue-based model that advances on the same rising edges. Scan results are also gathered bit by bit and compared with words built from the requirements.

// File: rtl/mem_tap_pkg.sv
package mem_tap_pkg;
  typedef enum logic [3:0] {
    TAP_TLR, TAP_RTI, TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR,
    TAP_UPD_DR, TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  typedef logic [IR_W-1:0] instr_t;

  localparam instr_t OP_EXTEST  = 3'b000;
  localparam instr_t OP_IDCODE  = 3'b001;
  localparam instr_t OP_SAMPLEZ = 3'b010;
  localparam instr_t OP_SAMPLE  = 3'b100;
  localparam instr_t OP_BYPASS  = 3'b111;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import mem_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e nxt;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      TAP_TLR:    nxt = tms_i ? TAP_TLR    : TAP_RTI;
      TAP_RTI:    nxt = tms_i ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_DR: nxt = tms_i ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: nxt = tms_i ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  nxt = tms_i ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: nxt = tms_i ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: nxt = tms_i ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: nxt = tms_i ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: nxt = tms_i ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_IR: nxt = tms_i ? TAP_TLR    : TAP_CAP_IR;
      TAP_CAP_IR: nxt = tms_i ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  nxt = tms_i ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: nxt = tms_i ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: nxt = tms_i ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: nxt = tms_i ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: nxt = tms_i ? TAP_SEL_DR : TAP_RTI;
      default:    nxt = TAP_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= TAP_TLR;
    else         state_o <= nxt;
  end
endmodule

// File: rtl/tap_shreg.sv
module tap_shreg #(
  parameter int W = 8
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         shift_i,
  input  logic [W-1:0] cap_val_i,
  input  logic         si_i,
  output logic [W-1:0] q_o
);
  if (W == 1) begin : g_one
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)      q_o <= '0;
      else if (cap_i)   q_o <= cap_val_i;
      else if (shift_i) q_o <= si_i;
    end
  end else begin : g_multi
    // serial in at MSB, out from LSB
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)      q_o <= '0;
      else if (cap_i)   q_o <= cap_val_i;
      else if (shift_i) q_o <= {si_i, q_o[W-1:1]};
    end
  end
endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import mem_tap_pkg::*;
(
  input  instr_t  ir_i,
  output dr_sel_e sel_o,
  output logic    odis_o
);
  always_comb begin
    sel_o  = SEL_BYP;
    odis_o = 1'b0;
    case (ir_i)
      OP_EXTEST, OP_SAMPLEZ: begin
        sel_o  = SEL_BSR;
        odis_o = 1'b1;
      end
      OP_SAMPLE: sel_o = SEL_BSR;
      OP_IDCODE: sel_o = SEL_ID;
      default:   sel_o = SEL_BYP;  // bypass and reserved codes
    endcase
  end
endmodule

// File: rtl/mem_tap.sv
module mem_tap
  import mem_tap_pkg::*;
#(
  parameter int         BSR_W  = 54,
  parameter logic [3:0] REV_P  = 4'h0,
  parameter logic [5:0] RSVD_P = 6'h00
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  input  logic [BSR_W-1:0] bsr_capture_i,
  output logic             tdo_o,
  output logic             tdo_en_o,
  output logic             out_disable_o
);
  localparam int          ID_W       = 32;
  localparam logic [4:0]  DEPTH_CODE = 5'b00111;
  localparam logic [4:0]  WIDTH_CODE = 5'b00011;
  localparam logic [10:0] VENDOR     = 11'b00011100100;
  localparam logic [ID_W-1:0] ID_WORD = {REV_P, DEPTH_CODE, WIDTH_CODE, RSVD_P, VENDOR, 1'b1};
  localparam instr_t      IR_CAPTURE = 3'b001;

  tap_state_e state_q;
  instr_t     ir_q;
  logic [IR_W-1:0]  ir_sh;
  logic [0:0]       byp_q;
  logic [ID_W-1:0]  id_q;
  logic [BSR_W-1:0] bsr_q;
  dr_sel_e    sel;
  logic       cap_dr, sh_dr, cap_ir, sh_ir, tdo_nxt;

  tap_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(state_q)
  );

  assign cap_dr = (state_q == TAP_CAP_DR);
  assign sh_dr  = (state_q == TAP_SH_DR);
  assign cap_ir = (state_q == TAP_CAP_IR);
  assign sh_ir  = (state_q == TAP_SH_IR);

  tap_shreg #(.W(IR_W)) u_ir_sh (
    .tck_i(tck_i), .rst_ni(rst_ni), .cap_i(cap_ir), .shift_i(sh_ir),
    .cap_val_i(IR_CAPTURE), .si_i(tdi_i), .q_o(ir_sh)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                    ir_q <= OP_IDCODE;
    else if (state_q == TAP_TLR)    ir_q <= OP_IDCODE;
    else if (state_q == TAP_UPD_IR) ir_q <= ir_sh;
  end

  tap_decode u_dec (
    .ir_i  (ir_q),
    .sel_o (sel),
    .odis_o(out_disable_o)
  );

  tap_shreg #(.W(1)) u_byp (
    .tck_i(tck_i), .rst_ni(rst_ni), .cap_i(cap_dr && sel == SEL_BYP),
    .shift_i(sh_dr && sel == SEL_BYP), .cap_val_i(1'b0), .si_i(tdi_i), .q_o(byp_q)
  );

  tap_shreg #(.W(ID_W)) u_id (
    .tck_i(tck_i), .rst_ni(rst_ni), .cap_i(cap_dr && sel == SEL_ID),
    .shift_i(sh_dr && sel == SEL_ID), .cap_val_i(ID_WORD), .si_i(tdi_i), .q_o(id_q)
  );

  tap_shreg #(.W(BSR_W)) u_bsr (
    .tck_i(tck_i), .rst_ni(rst_ni), .cap_i(cap_dr && sel == SEL_BSR),
    .shift_i(sh_dr && sel == SEL_BSR), .cap_val_i(bsr_capture_i), .si_i(tdi_i), .q_o(bsr_q)
  );

  always_comb begin
    if (sh_ir) tdo_nxt = ir_sh[0];
    else begin
      case (sel)
        SEL_ID:  tdo_nxt = id_q[0];
        SEL_BSR: tdo_nxt = bsr_q[0];
        default: tdo_nxt = byp_q[0];
      endcase
    end
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else begin
      tdo_o    <= tdo_nxt;
      tdo_en_o <= sh_dr || sh_ir;
    end
  end
endmodule

// File: rtl/mem_tap_chk.sv
module mem_tap_chk
  import mem_tap_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input tap_state_e      state_q,
  input instr_t          ir_q,
  input logic [IR_W-1:0] ir_sh,
  input logic [0:0]      byp_q,
  input logic            tdo_en_o,
  input logic            out_disable_o
);
  // R1
  tlr_idcode_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TAP_TLR) |=> (ir_q == OP_IDCODE));

  // R2
  tms_reset_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && $past(tms_i, 1) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
    |=> (state_q == TAP_TLR));

  // R3
  ir_capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TAP_CAP_IR) |=> (ir_sh == 3'b001));

  // R4
  odis_update_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(out_disable_o) |-> ($past(state_q) == TAP_UPD_IR || $past(state_q) == TAP_TLR));

  // R8
  bypass_zero_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TAP_CAP_DR && (ir_q == 3'b111 || ir_q == 3'b011 || ir_q == 3'b101 || ir_q == 3'b110))
    |=> (byp_q == 1'b0));

  // R9
  tdo_en_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == (state_q == TAP_SH_DR || state_q == TAP_SH_IR));
endmodule

bind mem_tap mem_tap_chk u_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .tms_i        (tms_i),
  .state_q      (state_q),
  .ir_q         (ir_q),
  .ir_sh        (ir_sh),
  .byp_q        (byp_q),
  .tdo_en_o     (tdo_en_o),
  .out_disable_o(out_disable_o)
);

// File: tb/mem_tap_test.sv
module mem_tap_test;
  localparam int BW = 54;
  localparam logic [31:0] EXP_ID = {4'd0, 5'b00111, 5'b00011, 6'd0, 11'b00011100100, 1'b1};
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_HDR = 4, S_E1D = 5, S_PDR = 6,
                 S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_HIR = 11, S_E1I = 12,
                 S_PIR = 13, S_E2I = 14, S_UIR = 15;

  logic tck_i = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b0;
  logic [BW-1:0] bsr_capture_i = '0;
  logic tdo_o, tdo_en_o, out_disable_o;

  int nchk = 0, nerr = 0;
  logic outbits[$];

  mem_tap uut (
    .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .bsr_capture_i(bsr_capture_i), .tdo_o(tdo_o), .tdo_en_o(tdo_en_o),
    .out_disable_o(out_disable_o)
  );

  always #10 tck_i = ~tck_i;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model
  int   mst;
  logic [2:0] mir;
  logic irq[$], drq[$];
  logic men, mtdo;

  function automatic int nxt(int s, logic t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;
      S_RTI: return t ? S_SDR : S_RTI;
      S_SDR: return t ? S_SIR : S_CDR;
      S_CDR, S_HDR: return t ? S_E1D : S_HDR;
      S_E1D: return t ? S_UDR : S_PDR;
      S_PDR: return t ? S_E2D : S_PDR;
      S_E2D: return t ? S_UDR : S_HDR;
      S_UDR, S_UIR: return t ? S_SDR : S_RTI;
      S_SIR: return t ? S_TLR : S_CIR;
      S_CIR, S_HIR: return t ? S_E1I : S_HIR;
      S_E1I: return t ? S_UIR : S_PIR;
      S_PIR: return t ? S_E2I : S_PIR;
      S_E2I: return t ? S_UIR : S_HIR;
      default: return S_TLR;
    endcase
  endfunction

  always @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst = S_TLR; mir = 3'b001; irq.delete(); drq.delete();
    end else begin
      case (mst)
        S_TLR: mir = 3'b001;
        S_CIR: begin irq.delete(); irq.push_back(1'b1); irq.push_back(1'b0); irq.push_back(1'b0); end
        S_HIR: begin void'(irq.pop_front()); irq.push_back(tdi_i); end
        S_UIR: mir = {irq[2], irq[1], irq[0]};
        S_CDR: begin
          drq.delete();
          if (mir == 3'b000 || mir == 3'b010 || mir == 3'b100)
            for (int i = 0; i < BW; i++) drq.push_back(bsr_capture_i[i]);
          else if (mir == 3'b001)
            for (int i = 0; i < 32; i++) drq.push_back(EXP_ID[i]);
          else drq.push_back(1'b0);
        end
        S_HDR: begin void'(drq.pop_front()); drq.push_back(tdi_i); end
        default: ;
      endcase
      mst = nxt(mst, tms_i);
    end
  end

  always @(negedge tck_i) begin
    men = (mst == S_HDR || mst == S_HIR);
    if (mst == S_HIR) mtdo = irq[0];
    else if (mst == S_HDR) mtdo = drq[0];
  end

  // lockstep compare, 5 ns after the falling edge
  always @(negedge tck_i) begin
    #5;
    if (rst_ni) begin
      chk(tdo_en_o === men, "R9 tdo_en lockstep", 64'(tdo_en_o), 64'(men));
      if (men) begin
        chk(tdo_o === mtdo, "R9 tdo lockstep", 64'(tdo_o), 64'(mtdo));
        outbits.push_back(tdo_o);
      end
      chk(out_disable_o === (mir == 3'b000 || mir == 3'b010), "R5 out_disable lockstep",
          64'(out_disable_o), 64'(mir == 3'b000 || mir == 3'b010));
    end
  end

  function automatic logic [63:0] packed_out();
    logic [63:0] v = '0;
    for (int i = 0; i < outbits.size() && i < 64; i++) v[i] = outbits[i];
    return v;
  endfunction

  task automatic step(input logic t, input logic d);
    tms_i = t; tdi_i = d;
    @(posedge tck_i); #5;
  endtask

  task automatic shift_ir(input logic [2:0] op);
    outbits.delete();
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, op[i]);
  endtask

  task automatic finish_ir();
    step(1, 0); step(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] op);
    shift_ir(op); finish_ir();
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din);
    outbits.delete();
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nchk++; nerr++;
    $display("FAIL R2 watchdog act=timeout exp=done");
    finish_sim();
  end

  initial begin
    logic [BW-1:0] pat;
    repeat (3) @(posedge tck_i);
    #5 rst_ni = 1'b1;
    chk(out_disable_o === 1'b0, "R1 reset out_disable", 64'(out_disable_o), 0);
    chk(tdo_en_o === 1'b0, "R1 reset tdo_en", 64'(tdo_en_o), 0);
    step(0, 0);
    scan_dr(32, 0);
    chk(packed_out() == 64'(EXP_ID), "R1 IDCODE after reset", packed_out(), 64'(EXP_ID));

    shift_ir(3'b001);
    chk(packed_out() == 64'd1, "R3 IR capture pattern", packed_out(), 64'd1);
    finish_ir();

    scan_dr(40, 64'h0000_00A6_0000_0000 >> 32);
    chk(packed_out()[31:0] == EXP_ID, "R7 ID word", 64'(packed_out()[31:0]), 64'(EXP_ID));
    chk(packed_out()[39:32] == 8'hA6, "R7 TDI after 32", 64'(packed_out()[39:32]), 64'hA6);

    for (int k = 0; k < 4; k++) begin
      logic [2:0] op;
      op = (k == 0) ? 3'b111 : (k == 1) ? 3'b011 : (k == 2) ? 3'b101 : 3'b110;
      load_ir(op);
      chk(out_disable_o === 1'b0, "R5 bypass/reserved no disable", 64'(out_disable_o), 0);
      scan_dr(8, 64'hB5);
      chk(packed_out()[7:0] == 8'h6A, "R8 bypass one-bit delay", 64'(packed_out()[7:0]), 64'h6A);
    end

    pat = 54'h2A_5C3F_0917_E6D4;
    bsr_capture_i = pat;
    load_ir(3'b000);
    chk(out_disable_o === 1'b1, "R5 EXTEST disable", 64'(out_disable_o), 1);
    scan_dr(BW, 0);
    chk(packed_out()[BW-1:0] == pat, "R6 EXTEST capture", 64'(packed_out()[BW-1:0]), 64'(pat));

    shift_ir(3'b111);
    chk(out_disable_o === 1'b1, "R4 held during IR shift", 64'(out_disable_o), 1);
    finish_ir();
    chk(out_disable_o === 1'b0, "R4 change after Update-IR", 64'(out_disable_o), 0);

    pat = 54'h15_A3C0_F6E8_192B;
    bsr_capture_i = pat;
    load_ir(3'b010);
    chk(out_disable_o === 1'b1, "R5 SAMPLE-Z disable", 64'(out_disable_o), 1);
    scan_dr(BW, 0);
    chk(packed_out()[BW-1:0] == pat, "R6 SAMPLE-Z capture", 64'(packed_out()[BW-1:0]), 64'(pat));

    pat = 54'h3F_0001_8000_FFFE;
    bsr_capture_i = pat;
    load_ir(3'b100);
    chk(out_disable_o === 1'b0, "R5 SAMPLE no disable", 64'(out_disable_o), 0);
    scan_dr(BW, 0);
    chk(packed_out()[BW-1:0] == pat, "R6 SAMPLE capture", 64'(packed_out()[BW-1:0]), 64'(pat));

    load_ir(3'b000);
    repeat (5) step(1, 0);
    chk(out_disable_o === 1'b0, "R1 TMS reset clears disable", 64'(out_disable_o), 0);
    step(0, 0);
    scan_dr(32, 0);
    chk(packed_out() == 64'(EXP_ID), "R1 IDCODE after TMS reset", packed_out(), 64'(EXP_ID));

    // pause in the middle of an ID scan
    outbits.delete();
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 10; i++) step(i == 9, 0);
    step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    for (int i = 0; i < 22; i++) step(i == 21, 0);
    step(1, 0); step(0, 0);
    chk(packed_out() == 64'(EXP_ID), "R2 scan across pause", packed_out(), 64'(EXP_ID));
    chk(tdo_en_o === 1'b0, "R9 tdo_en off in idle", 64'(tdo_en_o), 0);

    load_ir(3'b010);
    chk(out_disable_o === 1'b1, "R5 SAMPLE-Z again", 64'(out_disable_o), 1);
    rst_ni = 1'b0;
    @(posedge tck_i); #5;
    chk(out_disable_o === 1'b0, "R1 async reset disable", 64'(out_disable_o), 0);
    chk(tdo_en_o === 1'b0, "R1 async reset tdo_en", 64'(tdo_en_o), 0);
    rst_ni = 1'b1;
    step(0, 0);
    scan_dr(32, 0);
    chk(packed_out() == 64'(EXP_ID), "R1 IDCODE after async reset", packed_out(), 64'(EXP_ID));

    finish_sim();
  end
endmodule